// File: doc/BRIEF.md
# Shared Unit Handshake Merge and Arbiter

This block lets several four-phase request/acknowledge clients share one datapath unit. Each client raises its request and then keeps it high, together with the acknowledge it gets back, until its own instruction is over. The block picks one pending client, forwards a single request to the unit, and returns the unit's acknowledge only to that client.

The unit side is decoupled from the client side. As soon as the unit acknowledges, the block lowers the unit request and latches the client's acknowledge. The unit can then finish its return-to-zero and serve another client, while the first client is still holding its handshake high. This is how one unit can be used twice within one instruction.

A parameter selects between two policies. In merge mode, the requests are expected to be mutually exclusive, and simultaneous ones are settled by fixed priority. In arbiter mode, a mutual-exclusion stage handles requests that really do overlap, and it alternates fairly between clients.

Top module: `hs_share_arb`

## Requirements
- R1: While reset is high, and on the first cycle after it, `unit_req` and every bit of `cli_ack` are 0.
- R2: A client counts as pending when its `cli_req` bit is 1 and its `cli_ack` bit is 0. When the unit is idle and a client is pending at a rising clock edge, `unit_req` is 1 after that same edge.
- R3: `unit_req` stays 1 until the unit acknowledges. On the edge where `unit_ack` is sampled as 1, `unit_req` goes to 0 and the acknowledge bit of the granted client goes to 1.
- R4: A client's `cli_ack` bit stays 1 for as long as its `cli_req` bit stays 1, whatever the unit side does. It returns to 0 on the edge after `cli_req` is sampled as 0.
- R5: A grant is released on the edge where `unit_ack` is sampled as 0 after an acknowledge. Any client still pending is granted on the next edge, and `unit_req` rises with that grant.
- R6: In arbiter mode (`ARB_EN=1`), when several clients are pending at once, the search starts at the client after the previous winner. After reset, the previous winner counts as client `N_CLI-1`, so client 0 wins the first contest.
- R7: In merge mode (`ARB_EN=0`), when several clients are pending, the one with the lowest index wins, every time.
- R8: At most one client holds the grant at any time, and a `cli_ack` bit only rises for the client that holds the grant.
- R9: A client that has been served and keeps its request high is not granted the unit again.
- R10: After its acknowledge, the unit may hold `unit_ack` high for any number of cycles. It can then serve a second client while the first client's `cli_ack` is still 1, so both acknowledges can be high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req | input | N_CLI | Client request bits, one per client |
| cli_ack | output | N_CLI | Client acknowledge bits, registered |
| unit_req | output | 1 | Request towards the shared unit, registered |
| unit_ack | input | 1 | Acknowledge from the shared unit |

## Verification
The bench builds two copies of the block, both with `N_CLI=2`. One has `ARB_EN=1`: this reaches the alternating choice between truly concurrent requests, the back-to-back serving of the waiting client, and the state in which both acknowledges are held high together. The other has `ARB_EN=0`: this reaches the fixed-priority choice of merge mode, which repeats the same winner where the arbiter would alternate. With two clients, every grant order of the mutual-exclusion stage appears in short directed sequences.

// File: rtl/hs_share_pkg.sv
package hs_share_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_RTZ  = 2'd2
  } unit_phase_t;
endpackage

// File: rtl/hs_pick.sv
// Chooses one pending client: rotating priority (arbiter) or fixed priority (merge).
module hs_pick #(
  parameter int N_CLI  = 2,
  parameter bit ARB_EN = 1'b1,
  localparam int IW    = (N_CLI > 1) ? $clog2(N_CLI) : 1
) (
  input  logic [N_CLI-1:0] pending,
  input  logic [IW-1:0]    last_idx,
  output logic             any,
  output logic [IW-1:0]    sel_idx
);
  assign any = |pending;

  generate
    if (ARB_EN) begin : g_rr
      always_comb begin
        sel_idx = '0;
        for (int off = N_CLI; off >= 1; off--) begin
          if (pending[(int'(last_idx) + off) % N_CLI])
            sel_idx = IW'((int'(last_idx) + off) % N_CLI);
        end
      end
    end else begin : g_fix
      always_comb begin
        sel_idx = '0;
        for (int i = N_CLI - 1; i >= 0; i--) begin
          if (pending[i]) sel_idx = IW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hs_unit_seq.sv
// Unit-side four-phase sequencer: drives the unit request and tracks its return-to-zero.
module hs_unit_seq
  import hs_share_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic unit_ack,
  output logic unit_req,
  output logic idle,
  output logic done,
  output logic release_now
);
  unit_phase_t phase_q;

  assign idle        = (phase_q == PH_IDLE);
  assign done        = (phase_q == PH_REQ) && unit_ack;
  assign release_now = (phase_q == PH_RTZ) && !unit_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      unit_req <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q  <= PH_REQ;
          unit_req <= 1'b1;
        end
        PH_REQ: if (unit_ack) begin
          phase_q  <= PH_RTZ;
          unit_req <= 1'b0;
        end
        PH_RTZ: if (!unit_ack) phase_q <= PH_IDLE;
        default: begin
          phase_q  <= PH_IDLE;
          unit_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hs_ack_hold.sv
// Per-client acknowledge latch: set on unit completion, held until the client drops its request.
module hs_ack_hold (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic set,
  output logic ack
);
  always_ff @(posedge clk) begin
    if (rst)       ack <= 1'b0;
    else if (!req) ack <= 1'b0;
    else if (set)  ack <= 1'b1;
  end
endmodule

// File: rtl/hs_share_arb.sv
module hs_share_arb #(
  parameter int N_CLI  = 2,
  parameter bit ARB_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CLI-1:0] cli_req,
  output logic [N_CLI-1:0] cli_ack,
  output logic             unit_req,
  input  logic             unit_ack
);
  localparam int IW = (N_CLI > 1) ? $clog2(N_CLI) : 1;

  logic [N_CLI-1:0] pending;
  logic [N_CLI-1:0] grant_q;
  logic [IW-1:0]    last_q;
  logic [IW-1:0]    sel_idx;
  logic             any_pend;
  logic             seq_idle;
  logic             seq_done;
  logic             seq_release;
  logic             start;

  assign pending = cli_req & ~cli_ack;
  assign start   = seq_idle && any_pend;

  hs_pick #(.N_CLI(N_CLI), .ARB_EN(ARB_EN)) u_pick (
    .pending  (pending),
    .last_idx (last_q),
    .any      (any_pend),
    .sel_idx  (sel_idx)
  );

  hs_unit_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .unit_ack    (unit_ack),
    .unit_req    (unit_req),
    .idle        (seq_idle),
    .done        (seq_done),
    .release_now (seq_release)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= IW'(N_CLI - 1);
    end else if (start) begin
      grant_q <= N_CLI'(1) << sel_idx;
      last_q  <= sel_idx;
    end else if (seq_release) begin
      grant_q <= '0;
    end
  end

  generate
    for (genvar i = 0; i < N_CLI; i++) begin : g_cli
      hs_ack_hold u_hold (
        .clk (clk),
        .rst (rst),
        .req (cli_req[i]),
        .set (seq_done && grant_q[i]),
        .ack (cli_ack[i])
      );
    end
  endgenerate
endmodule

// File: rtl/hs_share_chk.sv
module hs_share_chk #(
  parameter int N_CLI = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CLI-1:0] cli_req,
  input logic [N_CLI-1:0] cli_ack,
  input logic             unit_req,
  input logic             unit_ack,
  input logic [N_CLI-1:0] grant
);
  p_grant_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_ack_only_granted_r8: assert property (@(posedge clk) disable iff (rst)
    ((cli_ack & ~$past(cli_ack) & ~$past(grant)) == '0));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (unit_req && !unit_ack) |=> unit_req);

  p_req_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(unit_req) |-> $past(unit_ack));

  p_ack_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(cli_ack & cli_req) & ~cli_ack) == '0));

  p_ack_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(~cli_req) & cli_ack) == '0));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(|grant) |-> !$past(unit_ack));

  p_req_needs_grant_r8: assert property (@(posedge clk) disable iff (rst)
    unit_req |-> (|grant));
endmodule

bind hs_share_arb hs_share_chk #(.N_CLI(N_CLI)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cli_req  (cli_req),
  .cli_ack  (cli_ack),
  .unit_req (unit_req),
  .unit_ack (unit_ack),
  .grant    (grant_q)
);

// File: tb/sim_hs_share_arb.sv
module sim_hs_share_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] a_req = '0, m_req = '0;
  logic [N-1:0] a_ack, m_ack;
  logic a_ureq, m_ureq;
  logic a_uack = 1'b0, m_uack = 1'b0;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_share_arb #(.N_CLI(N), .ARB_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .cli_req(a_req), .cli_ack(a_ack),
    .unit_req(a_ureq), .unit_ack(a_uack));

  hs_share_arb #(.N_CLI(N), .ARB_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .cli_req(m_req), .cli_ack(m_ack),
    .unit_req(m_ureq), .unit_ack(m_uack));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arbiter instance: unit acknowledges, expect client ack pattern, then unit returns to zero.
  task automatic a_serve(input string req, input logic [N-1:0] exp_ack);
    a_uack = 1'b1;
    tick();
    check({req, " unit_req low after ack"}, {3'b0, a_ureq}, 4'h0);
    check({req, " client ack"}, {2'b0, a_ack}, {2'b0, exp_ack});
    a_uack = 1'b0;
    tick();
  endtask

  task automatic m_serve(input string req, input logic [N-1:0] exp_ack);
    m_uack = 1'b1;
    tick();
    check({req, " merge client ack"}, {2'b0, m_ack}, {2'b0, exp_ack});
    m_uack = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 unit_req", {3'b0, a_ureq}, 4'h0);
    check("R1 cli_ack", {2'b0, a_ack}, 4'h0);
    check("R1 merge outputs", {1'b0, m_ureq, m_ack}, 4'h0);
  endtask

  task automatic t_first_contest();
    a_req = 2'b11;
    tick();
    check("R2 unit_req rises", {3'b0, a_ureq}, 4'h1);
    tick();
    check("R3 unit_req held", {3'b0, a_ureq}, 4'h1);
    a_serve("R6 first winner client0", 2'b01);
    tick();
    check("R5 waiting client served", {3'b0, a_ureq}, 4'h1);
    a_serve("R10 both acks held", 2'b11);
    a_req = 2'b00;
    tick();
    check("R4 acks drop", {2'b0, a_ack}, 4'h0);
  endtask

  task automatic t_single_hold();
    a_req = 2'b01;
    tick();
    check("R2 single request", {3'b0, a_ureq}, 4'h1);
    a_uack = 1'b1;
    tick();
    check("R3 ack to client0", {2'b0, a_ack}, 4'h1);
    tick();
    tick();
    check("R10 unit ack held, unit_req low", {3'b0, a_ureq}, 4'h0);
    check("R4 ack held", {2'b0, a_ack}, 4'h1);
    a_uack = 1'b0;
    tick();
    tick();
    tick();
    check("R9 no regrant", {3'b0, a_ureq}, 4'h0);
    check("R4 ack still held", {2'b0, a_ack}, 4'h1);
    a_req = 2'b00;
    tick();
    check("R4 ack drops after req", {2'b0, a_ack}, 4'h0);
    tick();
  endtask

  task automatic t_alternate();
    a_req = 2'b11;
    tick();
    a_serve("R6 alternation to client1", 2'b10);
    tick();
    a_serve("R6 then client0", 2'b11);
    a_req = 2'b00;
    tick();
    tick();
  endtask

  task automatic t_merge();
    for (int k = 0; k < 2; k++) begin
      m_req = 2'b11;
      tick();
      check("R7 merge unit_req", {3'b0, m_ureq}, 4'h1);
      m_serve("R7 lowest index first", 2'b01);
      tick();
      m_serve("R7 then client1", 2'b11);
      m_req = 2'b00;
      tick();
      tick();
    end
  endtask

  initial begin
    rst = 1'b1;
    tick();
    tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_first_contest();
    t_single_hold();
    t_alternate();
    t_merge();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000 && !finished) begin
        finished = 1'b1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule